// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port that sits on a simple 32-bit register bus with a valid/write/address/data handshake. Its data register is reachable at 256 consecutive word addresses. The eight address bits just above the byte offset act as a per-pin mask on every access. A write changes only the pins whose mask bit is set, and a read returns zero for every pin whose mask bit is clear. Several independent software agents can therefore own disjoint pins and update them with single stores, with no read-modify-write and no locking.

The port holds an output latch and a direction register. It drives the pad output value and the pad output enable, and it samples the pad input levels through a synchronizer. A read of the data register reports the latch value for output pins and the synchronized pad level for input pins. The latch can be preloaded through masked writes while a pin is still an input. The preloaded level appears at the pad as soon as the pin is switched to output.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted, and after reset until the first bus write, pin_out, pin_oe and bus_rdata are all zero.
- R2: A write to the data window (bus_addr[11:10] = 0) sets latch bit i to bus_wdata[i] when bus_addr[2+i] is 1, and leaves latch bit i unchanged when bus_addr[2+i] is 0. The latch is visible on pin_out the cycle after the write.
- R3: A read of the data window returns 0 in bit i whenever bus_addr[2+i] is 0.
- R4: A data read with mask bit i set returns the latch bit when direction bit i is 1 (output), and the synchronized input level when it is 0 (input).
- R5: The input level reported by a read captured at a clock edge is the pin_in value sampled two rising edges earlier.
- R6: bus_rdata is registered. It takes the read result on the clock edge that ends a read access (bus_valid=1, bus_write=0) and holds its value in every other cycle.
- R7: The direction register is at byte address 0x400, with bit value 1 meaning output. A write there loads bus_wdata[7:0], a read returns it, and pin_oe equals the direction register.
- R8: pin_out always shows the output latch, including bits written while their pin is an input. Such bits drive the pad once the direction bit is set.
- R9: bus_rdata[31:8] is always 0, and bus_wdata[31:8] has no effect on any register.
- R10: An access to any address outside the data window and other than 0x400 changes no register, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 9:2 form the pin mask inside the data window |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Pad input levels, asynchronous to clk |
| pin_out | output | 8 | Pad output values (output latch) |
| pin_oe | output | 8 | Pad output enables (direction register) |

## Verification
Two things can meet in one cycle: a masked data read, and a change of the synchronized input level. A pin_in edge that is still inside the synchronizer must not show up in that read. The bench changes pin_in at random on every cycle and issues back-to-back masked reads while the direction register holds a mix of inputs and outputs. A behavioural model with a two-deep sample queue predicts, for each read, which pin_in sample that read must return. A second collision is a masked write followed at once by a direction flip. The bench checks that the bits preloaded by that write appear on pin_out and become driven on pin_oe in the cycle after the flip.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } gpio_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_o = rst_pipe_q[1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  output gpio_sel_e         sel_o,
  output logic [DATA_W-1:0] mask_o
);

  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned WIN_LSB  = MASK_LSB + DATA_W;

  logic in_window;
  logic is_dir;
  logic unused_byte_bits;

  assign in_window = (bus_addr[ADDR_W-1:WIN_LSB] == '0);
  assign is_dir    = (bus_addr == DIR_OFFSET);
  assign mask_o    = bus_addr[MASK_LSB +: DATA_W];
  assign unused_byte_bits = ^bus_addr[MASK_LSB-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (bus_valid) begin
      if (in_window) begin
        sel_o = SEL_DATA;
      end else if (is_dir) begin
        sel_o = SEL_DIR;
      end
    end
  end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);

  logic              core_rst_n;
  gpio_sel_e         sel;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] in_sync;
  logic [DATA_W-1:0] pin_view;
  logic [DATA_W-1:0] wr_byte;
  logic              unused_wdata_hi;

  logic [DATA_W-1:0] latch_q, latch_d;
  logic [DATA_W-1:0] dir_q,   dir_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic              latch_en, dir_en, rdata_en;

  gpio_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  gpio_in_sync #(
    .WIDTH  (DATA_W),
    .STAGES (SYNC_DEPTH)
  ) u_in_sync (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .async_i (pin_in),
    .sync_o  (in_sync)
  );

  gpio_bus_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .DIR_OFFSET (DIR_OFFSET)
  ) u_decode (
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .sel_o     (sel),
    .mask_o    (mask)
  );

  assign wr_byte         = bus_wdata[DATA_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:DATA_W];

  // Per pin: outputs report the latch, inputs report the synchronized level.
  assign pin_view = (dir_q & latch_q) | (~dir_q & in_sync);

  always_comb begin
    latch_en = 1'b0;
    dir_en   = 1'b0;
    rdata_en = 1'b0;
    latch_d  = latch_q;
    dir_d    = dir_q;
    rdata_d  = rdata_q;

    if (bus_write) begin
      case (sel)
        SEL_DATA: begin
          latch_en = 1'b1;
          latch_d  = (latch_q & ~mask) | (wr_byte & mask);
        end
        SEL_DIR: begin
          dir_en = 1'b1;
          dir_d  = wr_byte;
        end
        default: ;
      endcase
    end else if (bus_valid) begin
      rdata_en = 1'b1;
      rdata_d  = '0;
      case (sel)
        SEL_DATA: rdata_d[DATA_W-1:0] = pin_view & mask;
        SEL_DIR:  rdata_d[DATA_W-1:0] = dir_q;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = latch_q;
  assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BUS_W      = 32,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] pin_oe
);

  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned WIN_LSB  = MASK_LSB + DATA_W;

  logic in_win, at_dir, rd_acc, wr_acc;
  assign in_win = (bus_addr[ADDR_W-1:WIN_LSB] == '0);
  assign at_dir = (bus_addr == DIR_OFFSET);
  assign rd_acc = bus_valid && !bus_write;
  assign wr_acc = bus_valid && bus_write;

  AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && in_win) |=>
      (((pin_out ^ $past(pin_out)) & ~$past(bus_addr[MASK_LSB +: DATA_W])) == '0) &&
      (((pin_out ^ $past(bus_wdata[DATA_W-1:0])) & $past(bus_addr[MASK_LSB +: DATA_W])) == '0)); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && in_win) |=> $stable(pin_out)); // R8

  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && in_win) |=> ((bus_rdata[DATA_W-1:0] & ~$past(bus_addr[MASK_LSB +: DATA_W])) == '0)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata)); // R6

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && at_dir) |=> (pin_oe == $past(bus_wdata[DATA_W-1:0]))); // R7

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !in_win && !at_dir) |=> (bus_rdata == '0)); // R10

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (bus_rdata[BUS_W-1:DATA_W] == '0)); // R9

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .BUS_W      (gpio_mask_pkg::BUS_W),
  .DIR_OFFSET (DIR_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cycles   = 0;
  bit    live     = 0;
  bit    done     = 0;
  string cur_tag  = "R1";

  // behavioural reference state
  logic [7:0]  m_latch;
  logic [7:0]  m_dir;
  logic [31:0] m_rdata;
  logic [7:0]  m_samples [$];

  gpio_mask_port u_gpio_mask_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model: one update per rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch   = 8'h00;
      m_dir     = 8'h00;
      m_rdata   = 32'h0;
      m_samples = '{8'h00, 8'h00};
    end else begin
      logic [7:0] old_in;
      logic [7:0] msk;
      bit         win;
      old_in = m_samples[$];
      void'(m_samples.pop_back());
      m_samples.push_front(pin_in);
      msk = bus_addr[9:2];
      win = (bus_addr[11:10] == 2'b00);
      if (bus_valid && bus_write) begin
        if (win) m_latch = (m_latch & ~msk) | (bus_wdata[7:0] & msk);
        else if (bus_addr == 12'h400) m_dir = bus_wdata[7:0];
      end else if (bus_valid) begin
        if (win) m_rdata = {24'h0, ((m_dir & m_latch) | (~m_dir & old_in)) & msk};
        else if (bus_addr == 12'h400) m_rdata = {24'h0, m_dir};
        else m_rdata = 32'h0;
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (live) begin
      check(cur_tag, "pin_out",   {24'h0, pin_out}, {24'h0, m_latch});
      check(cur_tag, "pin_oe",    {24'h0, pin_oe},  {24'h0, m_dir});
      check(cur_tag, "bus_rdata", bus_rdata,        m_rdata);
    end
  end

  task automatic idle();
    bus_valid = 1'b0;
    bus_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
    cur_tag   = tag;
    bus_valid = 1'b1;
    bus_write = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [11:0] a);
    cur_tag   = tag;
    bus_valid = 1'b1;
    bus_write = 1'b0;
    bus_addr  = a;
    bus_wdata = $urandom;
    @(negedge clk);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    pin_in    = '0;
    live      = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "oe in reset", {24'h0, pin_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "rdata after reset", bus_rdata, 32'h0);
    rd("R1", 12'h3FC);

    wr("R7", 12'h400, 32'h0000_00F0);
    rd("R7", 12'h400);
    wr("R2", 12'h3FC, 32'h0000_00A5);
    rd("R4", 12'h3FC);
    wr("R8", 12'h03C, 32'h0000_00FF);      // mask 0x0F: preload input-side bits
    rd("R2", 12'h3FC);
    rd("R3", 12'h0F0);                      // mask 0x3C
    wr("R8", 12'h400, 32'h0000_00FF);       // preloaded bits become driven
    wr("R9", 12'h3FC, 32'hFFFF_FF3C);
    rd("R9", 12'h3FC);
    wr("R7", 12'h400, 32'hFFFF_FF00);       // all inputs
    pin_in = 8'h5A;
    rd("R5", 12'h3FC);
    rd("R5", 12'h3FC);
    rd("R5", 12'h3FC);
    pin_in = 8'hC3;
    rd("R5", 12'h0FC);
    rd("R5", 12'h0FC);
    wr("R10", 12'h404, 32'h0000_0055);
    wr("R10", 12'h800, 32'h0000_0055);
    rd("R10", 12'hC00);
    rd("R10", 12'h404);
    cur_tag = "R6";
    pin_in  = 8'hFF;
    idle(); idle(); idle();
    rd("R6", 12'h400);
    idle(); idle();

    // Random mix: pin_in changes every cycle, collides with masked reads.
    for (int i = 0; i < 3000; i++) begin
      int          op;
      logic [11:0] a;
      pin_in = $urandom;
      op = $urandom_range(0, 9);
      if (op < 4)       a = 12'($urandom_range(0, 255) << 2) | 12'($urandom_range(0, 3));
      else if (op < 6)  a = 12'h400;
      else if (op < 7)  a = 12'($urandom_range(1025, 4095));
      else              a = 12'($urandom_range(0, 255) << 2);
      case ($urandom_range(0, 2))
        0: wr((op < 4) ? "R2" : (op < 6) ? "R7" : "R10", a, $urandom);
        1: rd((op < 4) ? "R3" : (op < 6) ? "R7" : (op < 7) ? "R10" : "R4", a);
        default: begin cur_tag = "R6"; idle(); end
      endcase
    end
    idle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule